// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that lets a bus host read and write a small bank of 8-bit configuration registers. The SCL and SDA lines arrive as raw input samples. They are synchronised to the system clock and examined for start, stop and clock edges. The slave drives the bus only through a pull-down enable for SDA, so the board forms the open-drain wired-AND.

The first byte after the address is a command. If its top bit is set, the lower seven bits name a register offset, and the host then moves one byte or a low/high byte pair at that offset. If its top bit is clear, the transfer is a block transfer anchored at register 0. A block write carries a byte count ahead of its data. A block read, reached through a repeated start, returns a count first and then the registers in ascending order. The register bank itself lives outside the block. It is reached through a registered write strobe and a combinational read port.

Top module: `smb_reg_slave`

## Requirements
- R1: A transaction whose 7-bit address differs from the DEV_ADDR parameter gets no acknowledge, never pulls SDA low and never issues a register write.
- R2: With command bit 7 = 1, the slave writes the data byte to the register at offset command[6:0]. It acknowledges the address, the command and the data byte (acknowledge = SDA held low during the ninth clock).
- R3: A word write with command bit 7 = 1 places the first data byte at the offset and the second at offset + 1.
- R4: Address+write, the command, a repeated start and then address+read (address LSB = 1) make the slave return the register at the commanded offset, most-significant bit first.
- R5: A word read returns the register at the offset first and the register at offset + 1 second. The host acknowledges the first byte and NACKs the second.
- R6: With command = 0x00, the first byte after the command is a byte count. The data bytes that follow go to registers 0, 1, 2 and upward. A stop after any complete byte keeps the bytes already written and leaves later registers unchanged.
- R7: A block read (command 0x00, repeated start, address+read) returns NUM_REGS as its first byte, then registers 0, 1 and upward, until the host NACKs.
- R8: A write to an offset at or beyond NUM_REGS is still acknowledged, but no register write strobe is issued. A read of such an offset returns 0x00.
- R9: The slave pulls SDA low only in its acknowledge slots and while it transmits 0 bits of a read byte. It releases SDA on any start or stop condition and never newly asserts the pull-down while SCL is high.
- R10: After reset, SDA is released and no register write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| sda_pull | output | 1 | 1 = pull SDA low |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_waddr | output | 7 | Register write offset |
| rf_wdata | output | 8 | Register write data |
| rf_raddr | output | 7 | Register read offset |
| rf_rdata | input | 8 | Register read data for rf_raddr |

## Verification
The bench targets the boundaries of the pointer. One word write straddles the last implemented register: a design without a range check would strobe offset 8, and a design that stops acknowledging would return a NACK there. A block read checks that the count byte comes first. A design that sends data first would shift every later byte by one register. A block write cut off after one data byte would expose a slave that buffers writes until the stop or that ignores the count byte. A foreign-address write that is followed by a read of the target register catches a slave that matches on the wrong bits. A check on every clock against the expected drive window catches any pull-down that lingers across a stop or into a host bit.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  localparam int OFFS_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } smb_state_e;
endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/smb_line_monitor.sv
module smb_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES;
  localparam int CUR  = SYNC_STAGES - 1;

  logic [LAST:0] scl_sr_q, sda_sr_q;
  logic [LAST:0] scl_sr_d, sda_sr_d;

  always_comb begin
    scl_sr_d = {scl_sr_q[LAST-1:0], scl_in};
    sda_sr_d = {sda_sr_q[LAST-1:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr_q <= '1;
      sda_sr_q <= '1;
    end else begin
      scl_sr_q <= scl_sr_d;
      sda_sr_q <= sda_sr_d;
    end
  end

  assign sda_s     = sda_sr_q[CUR];
  assign scl_rise  = scl_sr_q[CUR] & ~scl_sr_q[LAST];
  assign scl_fall  = ~scl_sr_q[CUR] & scl_sr_q[LAST];
  assign start_det = scl_sr_q[CUR] & scl_sr_q[LAST] & ~sda_sr_q[CUR] & sda_sr_q[LAST];
  assign stop_det  = scl_sr_q[CUR] & scl_sr_q[LAST] & sda_sr_q[CUR] & ~sda_sr_q[LAST];
endmodule

// File: rtl/smb_xfer_engine.sv
module smb_xfer_engine
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              rf_we,
  output logic [OFFS_W-1:0] rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic [OFFS_W-1:0] rf_raddr,
  input  logic [BYTE_W-1:0] rf_rdata
);
  localparam logic [BYTE_W-1:0] NREG8 = BYTE_W'(NUM_REGS);

  smb_state_e        st_q, st_d, nxt_q, nxt_d;
  logic [3:0]        bc_q, bc_d, bc_inc;
  logic [7:0]        sh_q, sh_d, tx_q, tx_d;
  logic [OFFS_W-1:0] ptr_q, ptr_d;
  logic              blk_q, blk_d, cntp_q, cntp_d, sendc_q, sendc_d;
  logic              hack_q, hack_d, pull_q, pull_d;
  logic              we_q, we_d;
  logic [OFFS_W-1:0] wa_q, wa_d;
  logic [7:0]        wd_q, wd_d;
  logic              in_range;
  logic [7:0]        load_val;

  assign in_range = ({1'b0, ptr_q} < NREG8);
  assign load_val = sendc_q ? NREG8 : (in_range ? rf_rdata : 8'h00);
  assign bc_inc   = bc_q + 4'd1;

  always_comb begin
    st_d    = st_q;   nxt_d  = nxt_q;  bc_d   = bc_q;   sh_d   = sh_q;
    tx_d    = tx_q;   ptr_d  = ptr_q;  blk_d  = blk_q;  cntp_d = cntp_q;
    sendc_d = sendc_q; hack_d = hack_q; pull_d = pull_q;
    we_d    = 1'b0;   wa_d   = wa_q;   wd_d   = wd_q;
    if (start_det) begin
      st_d = ST_ADDR; bc_d = 4'd0; pull_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; pull_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_s};
            bc_d = bc_inc;
          end else if (scl_fall && bc_q == 4'd8) begin
            bc_d = 4'd0; st_d = ST_ACK; pull_d = 1'b1;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] != DEV_ADDR) begin
                st_d = ST_IDLE; pull_d = 1'b0;
              end else if (sh_q[0]) begin
                nxt_d = ST_TX; sendc_d = blk_q;
              end else begin
                nxt_d = ST_CMD;
              end
            end else if (st_q == ST_CMD) begin
              blk_d  = ~sh_q[7];
              cntp_d = ~sh_q[7];
              ptr_d  = sh_q[7] ? sh_q[6:0] : '0;
              nxt_d  = ST_WDATA;
            end else begin
              nxt_d = ST_WDATA;
              if (cntp_q) begin
                cntp_d = 1'b0;
              end else begin
                if (in_range) begin
                  we_d = 1'b1; wa_d = ptr_q; wd_d = sh_q;
                end
                ptr_d = ptr_q + 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bc_d = 4'd0; st_d = nxt_q; pull_d = 1'b0;
            if (nxt_q == ST_TX) begin
              tx_d = load_val; pull_d = ~load_val[7];
              if (sendc_q) sendc_d = 1'b0;
              else         ptr_d   = ptr_q + 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bc_q == 4'd7) begin
              st_d = ST_MACK; pull_d = 1'b0;
            end else begin
              bc_d   = bc_inc;
              pull_d = ~tx_q[~bc_inc[2:0]];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              st_d = ST_TX; bc_d = 4'd0;
              tx_d = load_val; pull_d = ~load_val[7];
              if (sendc_q) sendc_d = 1'b0;
              else         ptr_d   = ptr_q + 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; nxt_q <= ST_IDLE; bc_q <= '0; sh_q <= '0; tx_q <= '0;
      ptr_q <= '0; blk_q <= 1'b0; cntp_q <= 1'b0; sendc_q <= 1'b0;
      hack_q <= 1'b0; pull_q <= 1'b0; we_q <= 1'b0; wa_q <= '0; wd_q <= '0;
    end else begin
      st_q <= st_d; nxt_q <= nxt_d; bc_q <= bc_d; sh_q <= sh_d; tx_q <= tx_d;
      ptr_q <= ptr_d; blk_q <= blk_d; cntp_q <= cntp_d; sendc_q <= sendc_d;
      hack_q <= hack_d; pull_q <= pull_d; we_q <= we_d; wa_q <= wa_d; wd_q <= wd_d;
    end
  end

  assign sda_pull = pull_q;
  assign rf_we    = we_q;
  assign rf_waddr = wa_q;
  assign rf_wdata = wd_q;
  assign rf_raddr = ptr_q;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic              rf_we,
  output logic [OFFS_W-1:0] rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic [OFFS_W-1:0] rf_raddr,
  input  logic [BYTE_W-1:0] rf_rdata
);
  logic rst_sync_n;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  smb_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_xfer_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       rf_we,
  input logic [6:0] rf_waddr
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  assert_pull_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  assert_release_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  assert_write_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ({1'b0, rf_waddr} < NREG8));

  assert_single_write_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .sda_pull(sda_pull), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/smb_reg_slave_tb_top.sv
module smb_reg_slave_tb_top;
  localparam int         NREGS = 8;
  localparam logic [6:0] DEV   = 7'h69;
  localparam int         Q     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_pull, rf_we;
  logic [6:0] rf_waddr, rf_raddr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] regs_q [0:NREGS-1];
  logic sda_line;
  bit   may_drive = 1'b0;
  bit   run_chk = 1'b0;
  int   vec = 0, miss = 0;
  int   mdl [0:NREGS-1];

  always #2.5 clk = ~clk;

  assign sda_line = sda_h & ~sda_pull;
  assign rf_rdata = (int'(rf_raddr) < NREGS) ? regs_q[rf_raddr[2:0]] : 8'hEE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= 8'h00;
    end else if (rf_we && int'(rf_waddr) < NREGS) begin
      regs_q[rf_waddr[2:0]] <= rf_wdata;
    end
  end

  smb_reg_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
    .sda_pull(sda_pull), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference: drive only inside expected windows, never strobe out of range
  always @(negedge clk) begin
    if (run_chk) begin
      chk(!(scl_h && sda_pull && !may_drive), "R9 pull outside slave slot", sda_pull, 0);
      chk(!(rf_we && int'(rf_waddr) >= NREGS), "R8 out-of-range strobe", rf_waddr, 0);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b0; wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b1; wt(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wt(Q); scl_h = 1'b1; wt(2*Q); scl_h = 1'b0; wt(Q);
    end
    sda_h = 1'b1; may_drive = 1'b1; wt(Q);
    scl_h = 1'b1; wt(Q); ack = ~sda_line; wt(Q); scl_h = 1'b0;
    wt(6); may_drive = 1'b0; wt(Q-6);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    sda_h = 1'b1; may_drive = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_h = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_h = 1'b0;
      if (i == 0) begin wt(6); may_drive = 1'b0; wt(Q-6); end
      else wt(Q);
    end
    sda_h = nack; wt(Q); scl_h = 1'b1; wt(2*Q); scl_h = 1'b0; sda_h = 1'b1; wt(Q);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd,
                          input logic [7:0] data[$], input bit exp_ack, input string req);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, ack); chk(ack == exp_ack, {req, " address ack"}, ack, exp_ack);
    send_byte(cmd, ack);       chk(ack == exp_ack, {req, " command ack"}, ack, exp_ack);
    foreach (data[i]) begin
      send_byte(data[i], ack); chk(ack == exp_ack, {req, " data ack"}, ack, exp_ack);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, input int exp[$], input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, {req, " address ack"}, ack, 1);
    send_byte(cmd, ack);         chk(ack, {req, " command ack"}, ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, {req, " read address ack"}, ack, 1);
    foreach (exp[i]) begin
      recv_byte(b, i == exp.size() - 1);
      chk(int'(b) == exp[i], {req, " read byte"}, b, exp[i]);
    end
    bus_stop();
  endtask

  initial begin
    int blk[$];
    for (int i = 0; i < NREGS; i++) mdl[i] = 0;
    wt(5); rst_n = 1'b1; wt(10);
    chk(sda_pull == 1'b0, "R10 pull after reset", sda_pull, 0);
    chk(rf_we == 1'b0, "R10 strobe after reset", rf_we, 0);
    run_chk = 1'b1;

    // R2 byte write, R4 byte read
    do_write(DEV, 8'h83, '{8'hA5}, 1'b1, "R2"); mdl[3] = 'hA5;
    do_read(8'h83, '{mdl[3]}, "R4");

    // R3 word write, R5 word read
    do_write(DEV, 8'h85, '{8'h3C, 8'hC3}, 1'b1, "R3"); mdl[5] = 'h3C; mdl[6] = 'hC3;
    do_read(8'h85, '{mdl[5], mdl[6]}, "R5");

    // R6 block write with count
    do_write(DEV, 8'h00, '{8'h03, 8'h11, 8'h22, 8'h33}, 1'b1, "R6");
    mdl[0] = 'h11; mdl[1] = 'h22; mdl[2] = 'h33;

    // R7 full block read: count then registers 0..7
    blk = '{NREGS};
    for (int i = 0; i < NREGS; i++) blk.push_back(mdl[i]);
    do_read(8'h00, blk, "R7");

    // R6 block write stopped after one data byte
    do_write(DEV, 8'h00, '{8'h04, 8'h77}, 1'b1, "R6 cut"); mdl[0] = 'h77;
    do_read(8'h00, '{NREGS, mdl[0], mdl[1]}, "R7 partial");

    // R1 foreign address ignored
    do_write(7'h12, 8'h83, '{8'hFF}, 1'b0, "R1");
    do_read(8'h83, '{mdl[3]}, "R1 unchanged");

    // R8 out of range write acked, discarded, reads zero
    do_write(DEV, 8'hC0, '{8'h99}, 1'b1, "R8");
    do_read(8'hC0, '{0}, "R8 read zero");
    do_write(DEV, 8'h87, '{8'h44, 8'h55}, 1'b1, "R8 straddle"); mdl[7] = 'h44;
    do_read(8'h87, '{mdl[7], 0}, "R8 straddle read");

    for (int i = 0; i < NREGS; i++)
      chk(int'(regs_q[i]) == mdl[i], "R6 final register image", regs_q[i], mdl[i]);
    chk(sda_pull == 1'b0, "R9 released at idle", sda_pull, 0);

    run_chk = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    wt(150000);
    miss++; vec++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule